// File: doc/BRIEF.md
# Pattern Fill-and-Verify Memory Self-Test Sequencer

This block tests a region of 32-bit word memory through a simple synchronous master port. After a start pulse it runs a fixed chain of seven data passes. In each pass it first writes a computed word to every location of the current test window. Then it reads every location back and compares it with the same computed word. The passes use four constant words, a walking-one word, the word's own index and the inverted index.

A mode input picks one of two coverage plans. In full mode a single window spans the whole region. In sampled mode the region is cut into whole megabytes, and two 2 KB windows are tested around each megabyte boundary. The first mismatch ends the whole run. The block then holds the failing byte address, the expected word and the word read until the next start. A watchdog-kick pulse is produced at regular points so that a long run can keep an external watchdog fed.

Top module: `mtest_seq`

## Requirements
- R1: The passes run in this order, each with the same value in every word: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA. Three more passes follow (R2, R3).
- R2: The fifth pass writes and expects, at window word index i, the value 1 shifted left by (i mod 32).
- R3: The sixth pass uses the value i at word index i. The seventh pass uses the bitwise inverse of i.
- R4: Each pass writes every word of the window in ascending order, one write per cycle, before it issues any read. Reads then go in ascending order. Read data must be on mem_rdata_i in the cycle after the read request, and at least one idle cycle follows each read.
- R5: A verify mismatch ends the run at once, with no further memory access. fail_o and done_o both go high. fail_addr_o holds the byte address of the failing word, fail_exp_o the expected word and fail_got_o the word read.
- R6: In sampled mode (sampled_i=1), for each whole megabyte k of size_i, the seven passes run on 512 words at base_i + k*0x100000. They then run on 512 words at base_i + k*0x100000 + 0xFF800. Window word index i maps to byte address window start + 4*i.
- R7: In sampled mode with a size under 0x100000, the run ends with done_o=1 and fail_o=0 within three cycles, and makes no memory access.
- R8: In full mode, one seven-pass series covers size_i/4 words from base_i. Every access falls inside [base_i, base_i+size_i).
- R9: kick_o pulses for one cycle in three cases: on every write or read request whose window word index is a multiple of 1024, and in the cycle each pass completes its verify with no mismatch.
- R10: busy_o is high from the cycle after start until the run ends, and start_i is ignored while busy. done_o and fail_o hold their values until the next start.
- R11: After reset, busy_o, done_o, fail_o, mem_req_o and kick_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| sampled_i | input | 1 | 1 = sampled windows, 0 = full region |
| base_i | input | AW | Region start byte address (word aligned) |
| size_i | input | AW | Region size in bytes |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until next start |
| fail_o | output | 1 | Run ended on a mismatch |
| fail_addr_o | output | AW | Byte address of the failing word |
| fail_exp_o | output | 32 | Expected word at the failure |
| fail_got_o | output | 32 | Word read at the failure |
| kick_o | output | 1 | Watchdog-kick pulse |

## Verification
A correct memory never shows the early-stop behaviour. To reach it, the bench's memory model corrupts reads at one chosen address. One case forces a bit low, so the run passes the all-zero pass and fails in the all-ones pass in the middle of the region. Another case forces a bit high at the last word, so the run fails in the very first pass. The kick spacing of 1024 words shows up only in windows longer than 1024 words. A full-mode run over 1100 words produces the mid-window pulses. A two-megabyte sampled run walks all four windows, including the window that ends exactly at the region end.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

  typedef enum logic [2:0] {
    PS_ZERO, PS_ONES, PS_CHK5, PS_CHKA, PS_WALK, PS_IDX, PS_NIDX
  } pass_e;

  localparam pass_e PASS_LAST = PS_NIDX;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WIN, ST_FILL, ST_RD, ST_CMP
  } st_e;

  // Data word of pass p at window word index i (R1, R2, R3)
  function automatic logic [31:0] pass_word(pass_e p, logic [31:0] i);
    logic [31:0] w;
    case (p)
      PS_ZERO: w = 32'h0000_0000;
      PS_ONES: w = 32'hFFFF_FFFF;
      PS_CHK5: w = 32'h5555_5555;
      PS_CHKA: w = 32'hAAAA_AAAA;
      PS_WALK: w = 32'h1 << i[4:0];
      PS_IDX:  w = i;
      default: w = ~i;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mtest_window.sv
module mtest_window #(
  parameter int AW        = 24,
  parameter int MB_SHIFT  = 20,
  parameter int WIN_BYTES = 2048,
  parameter int SIDE_OFF  = 32'h000F_F800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          sampled_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic          next_i,
  output logic          valid_o,
  output logic [AW-1:0] base_o,
  output logic [AW-2:0] words_o,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o
);
  localparam int NW = AW - MB_SHIFT + 1;
  localparam int WW = AW - 1;

  logic          sampled_q;
  logic [AW-1:0] base_q, size_q;
  logic [NW-1:0] widx_q;
  logic [NW-1:0] nwin;
  logic [AW-1:0] mb_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled_q <= 1'b0;
      base_q    <= '0;
      size_q    <= '0;
      widx_q    <= '0;
    end else if (load_i) begin
      sampled_q <= sampled_i;
      base_q    <= base_i;
      size_q    <= size_i;
      widx_q    <= '0;
    end else if (next_i) begin
      widx_q    <= widx_q + 1'b1;
    end
  end

  // two windows per whole megabyte
  assign nwin   = {size_q[AW-1:MB_SHIFT], 1'b0};
  assign mb_off = AW'(widx_q >> 1) << MB_SHIFT;

  always_comb begin
    if (sampled_q) begin
      valid_o = widx_q < nwin;
      base_o  = base_q + mb_off + (widx_q[0] ? AW'(SIDE_OFF) : '0);
      words_o = WW'(WIN_BYTES / 4);
    end else begin
      valid_o = (widx_q == '0) && (size_q[AW-1:2] != '0);
      base_o  = base_q;
      words_o = {1'b0, size_q[AW-1:2]};
    end
  end

  assign lo_o = base_q;
  assign hi_o = base_q + size_q;

  AST_WIN_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && sampled_q) |-> (base_o + AW'(WIN_BYTES) <= hi_o)); // R6

  AST_WIDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled_q && !load_i) |-> (widx_q <= nwin)); // R6

endmodule

// File: rtl/mtest_kick.sv
module mtest_kick #(
  parameter int KICK_WORDS = 1024,
  localparam int KB = $clog2(KICK_WORDS)
) (
  input  logic          access_i,
  input  logic [KB-1:0] idx_lo_i,
  input  logic          pass_end_i,
  output logic          kick_o
);
  assign kick_o = (access_i && (idx_lo_i == '0)) || pass_end_i;
endmodule

// File: rtl/mtest_seq.sv
module mtest_seq
  import mtest_pkg::*;
#(
  parameter int AW         = 24,
  parameter int MB_SHIFT   = 20,
  parameter int WIN_BYTES  = 2048,
  parameter int SIDE_OFF   = 32'h000F_F800,
  parameter int KICK_WORDS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sampled_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [31:0]   fail_exp_o,
  output logic [31:0]   fail_got_o,
  output logic          kick_o
);
  localparam int WW = AW - 1;
  localparam int KB = $clog2(KICK_WORDS);

  st_e           state_q;
  pass_e         pass_q;
  logic [WW-1:0] idx_q;
  logic          done_q, fail_q;
  logic [AW-1:0] faddr_q;
  logic [31:0]   fexp_q, fgot_q;

  // named internal events
  logic          load_evt, win_ok, last_word, miscmp, pass_end, series_end;
  logic [AW-1:0] win_base, rgn_lo, rgn_hi, cur_addr;
  logic [WW-1:0] win_words;
  logic [31:0]   cur_word;

  assign load_evt = (state_q == ST_IDLE) && start_i;

  mtest_window #(
    .AW(AW), .MB_SHIFT(MB_SHIFT), .WIN_BYTES(WIN_BYTES), .SIDE_OFF(SIDE_OFF)
  ) win_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .sampled_i(sampled_i),
    .base_i(base_i), .size_i(size_i), .next_i(series_end),
    .valid_o(win_ok), .base_o(win_base), .words_o(win_words),
    .lo_o(rgn_lo), .hi_o(rgn_hi)
  );

  assign cur_addr   = win_base + AW'({idx_q, 2'b00});
  assign cur_word   = pass_word(pass_q, 32'(idx_q));
  assign last_word  = (idx_q == win_words - 1'b1);
  assign miscmp     = (state_q == ST_CMP) && (mem_rdata_i != cur_word);
  assign pass_end   = (state_q == ST_CMP) && !miscmp && last_word;
  assign series_end = pass_end && (pass_q == PASS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= PS_ZERO;
      idx_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          state_q <= ST_WIN;
        end
        ST_WIN: if (win_ok) begin
          pass_q  <= PS_ZERO;
          idx_q   <= '0;
          state_q <= ST_FILL;
        end else begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_FILL: if (last_word) begin
          idx_q   <= '0;
          state_q <= ST_RD;
        end else begin
          idx_q   <= idx_q + 1'b1;
        end
        ST_RD: state_q <= ST_CMP;
        ST_CMP: if (miscmp) begin
          fail_q  <= 1'b1;
          done_q  <= 1'b1;
          faddr_q <= cur_addr;
          fexp_q  <= cur_word;
          fgot_q  <= mem_rdata_i;
          state_q <= ST_IDLE;
        end else if (last_word) begin
          idx_q <= '0;
          if (pass_q == PASS_LAST) begin
            state_q <= ST_WIN;
          end else begin
            pass_q  <= pass_e'(pass_q + 3'd1);
            state_q <= ST_FILL;
          end
        end else begin
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_RD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_FILL) || (state_q == ST_RD);
  assign mem_we_o    = (state_q == ST_FILL);
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = mem_we_o ? cur_word : '0;

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = faddr_q;
  assign fail_exp_o  = fexp_q;
  assign fail_got_o  = fgot_q;

  mtest_kick #(.KICK_WORDS(KICK_WORDS)) kick_i (
    .access_i(mem_req_o), .idx_lo_i(idx_q[KB-1:0]),
    .pass_end_i(pass_end), .kick_o(kick_o)
  );

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o); // R5

  AST_QUIET_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miscmp |=> (!mem_req_o && fail_o)); // R5

  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !series_end) |=> (pass_q == pass_e'($past(pass_q) + 3'd1))); // R1

  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o); // R4

  AST_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ((mem_addr_o >= rgn_lo) && (mem_addr_o < rgn_hi))); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10

endmodule

// File: tb/mtest_seq_tb_top.sv
module mtest_seq_tb_top;
  localparam int AW = 24;

  typedef struct {
    bit          we;
    int          addr;
    logic [31:0] data;
    string       tag;
  } acc_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          sampled_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] size_i = '0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [31:0]   mem_rdata_i = '0;
  logic          busy_o, done_o, fail_o, kick_o;
  logic [AW-1:0] fail_addr_o;
  logic [31:0]   fail_exp_o, fail_got_o;

  int n_vec = 0;
  int n_bad = 0;
  int kick_cnt = 0;
  acc_t exp_q[$];

  logic [31:0] mem [int];
  int          f_addr = -1;
  logic [31:0] f_clr = '0;
  logic [31:0] f_set = '0;

  always #4 clk = ~clk;  // 125 MHz

  mtest_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sampled_i(sampled_i),
    .base_i(base_i), .size_i(size_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o),
    .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o), .kick_o(kick_o)
  );

  function automatic logic [31:0] faulty(int a, logic [31:0] d);
    return (a == f_addr) ? ((d & ~f_clr) | f_set) : d;
  endfunction

  // memory model: read data registered, one cycle after the request
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
      else mem_rdata_i <= faulty(int'(mem_addr_o),
                            mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 32'h0);
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && kick_o) kick_cnt++;
    if (rst_n && mem_req_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected access", longint'(mem_addr_o), 0);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(mem_we_o == e.we, {e.tag, " kind"}, longint'(mem_we_o), longint'(e.we));
        chk(int'(mem_addr_o) == e.addr, {e.tag, " addr"}, longint'(mem_addr_o), longint'(e.addr));
        if (e.we)
          chk(mem_wdata_o == e.data, {e.tag, " data"}, longint'(mem_wdata_o), longint'(e.data));
      end
    end
  end

  // bench's own restatement of the seven data series
  function automatic logic [31:0] model_word(int p, int i);
    logic [31:0] iv;
    iv = 32'(i);
    case (p)
      0: return 32'h0;
      1: return ~32'h0;
      2: return {16{2'b01}};
      3: return {16{2'b10}};
      4: return 32'(1) << (i % 32);
      5: return iv;
      default: return ~iv;
    endcase
  endfunction

  function automatic string pass_tag(int p);
    if (p < 4) return "R1";
    if (p == 4) return "R2";
    return "R3";
  endfunction

  // driver: pushes expected accesses and result
  task automatic plan_run(bit smp, int base, int size, output bit xfail,
                          output int xaddr, output logic [31:0] xexp,
                          output logic [31:0] xgot, output int xkicks);
    int wb[$];
    int wn[$];
    bit stop;
    xfail = 0; xaddr = 0; xexp = 0; xgot = 0; xkicks = 0; stop = 0;
    if (smp) begin
      for (int k = 0; k < (size >>> 20); k++) begin
        wb.push_back(base + k * 32'h10_0000);           wn.push_back(512);
        wb.push_back(base + k * 32'h10_0000 + 32'hFF800); wn.push_back(512);
      end
    end else if (size >= 4) begin
      wb.push_back(base); wn.push_back(size / 4);
    end
    for (int w = 0; w < wb.size() && !stop; w++) begin
      for (int p = 0; p < 7 && !stop; p++) begin
        for (int i = 0; i < wn[w]; i++) begin
          acc_t e;
          e.we = 1; e.addr = wb[w] + 4 * i; e.data = model_word(p, i);
          e.tag = smp ? "R6" : pass_tag(p);
          exp_q.push_back(e);
          if (i % 1024 == 0) xkicks++;
        end
        for (int i = 0; i < wn[w] && !stop; i++) begin
          acc_t e;
          logic [31:0] rd;
          e.we = 0; e.addr = wb[w] + 4 * i; e.data = 0; e.tag = "R4";
          exp_q.push_back(e);
          if (i % 1024 == 0) xkicks++;
          rd = faulty(e.addr, model_word(p, i));
          if (rd != model_word(p, i)) begin
            stop = 1; xfail = 1; xaddr = e.addr; xexp = model_word(p, i); xgot = rd;
          end
        end
        if (!stop) xkicks++;
      end
    end
  endtask

  task automatic run_case(bit smp, int base, int size, bit poke_start);
    bit xf; int xa; logic [31:0] xe, xg; int xk; int cyc;
    plan_run(smp, base, size, xf, xa, xe, xg, xk);
    kick_cnt = 0;
    sampled_i = smp; base_i = AW'(base); size_i = AW'(size);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    if (poke_start) begin
      repeat (20) @(negedge clk);
      chk(busy_o == 1'b1, "R10 busy during run", longint'(busy_o), 1);
      sampled_i = ~smp; base_i = '0;  // start while busy must be ignored (R10)
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      sampled_i = smp; base_i = AW'(base);
      cyc += 21;
    end
    while (!done_o) begin
      @(negedge clk);
      cyc++;
    end
    if (smp && size < 32'h10_0000)
      chk(cyc <= 3, "R7 quick finish", longint'(cyc), 3);
    chk(fail_o == xf, "R5 fail flag", longint'(fail_o), longint'(xf));
    if (xf) begin
      chk(int'(fail_addr_o) == xa, "R5 fail addr", longint'(fail_addr_o), longint'(xa));
      chk(fail_exp_o == xe, "R5 fail expected", longint'(fail_exp_o), longint'(xe));
      chk(fail_got_o == xg, "R5 fail read", longint'(fail_got_o), longint'(xg));
    end
    chk(exp_q.size() == 0, "R4 accesses left", longint'(exp_q.size()), 0);
    chk(kick_cnt == xk, "R9 kick count", longint'(kick_cnt), longint'(xk));
    chk(busy_o == 1'b0, "R10 idle at end", longint'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk(done_o == 1'b1 && fail_o == xf, "R10 result held",
        longint'({done_o, fail_o}), longint'({1'b1, xf}));
    exp_q.delete();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, fail_o, mem_req_o, kick_o} == 5'b0, "R11 reset state",
        longint'({busy_o, done_o, fail_o, mem_req_o, kick_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // full mode, 64 words, start poked while busy
    run_case(1'b0, 32'h1000, 256, 1'b1);           // R8 R1 R2 R3
    // full mode, 1100 words: mid-window kicks
    run_case(1'b0, 32'h8000, 4400, 1'b0);          // R9
    // sampled mode, under one megabyte: no windows
    run_case(1'b1, 32'h4_0000, 32'hC_0000, 1'b0);  // R7
    // sampled mode, two megabytes: four windows
    run_case(1'b1, 32'h4_0000, 32'h20_0000, 1'b0); // R6
    // stuck-low bit 3 mid region: fails in the all-ones pass
    f_addr = 32'h1040; f_clr = 32'h8; f_set = '0;
    run_case(1'b0, 32'h1000, 256, 1'b0);           // R5
    // stuck-high bit 31 at last word: fails in the first pass
    f_addr = 32'h20FC; f_clr = '0; f_set = 32'h8000_0000;
    run_case(1'b0, 32'h2000, 256, 1'b0);           // R5
    f_addr = -1; f_clr = '0; f_set = '0;
    summary();
  end

endmodule